// File: doc/BRIEF.md
# Gigabit Transmit Test Pattern Generator

This block produces the repeating symbol stream that a gigabit twisted-pair transmitter sends in one of its test modes. The same signed five-level symbol goes out on each of four lanes. One symbol is sent per clock, and in the target system the clock runs at 125 MHz, which gives 125 Msymbol/s on each pair. The stream is built from six segments in a fixed order. First come four isolated impulses of +2, -2, +1 and -1, each followed by silence. Then a run of +2 symbols is followed by a run of -2 symbols. A long stretch of zero symbols ends the period, and the pattern then starts over.

A controller holds `run_en` high to stream symbols. While it is low, the output is forced to zero, the valid flag is low, and the position in the pattern is kept. A one-cycle `restart` pulse sends the generator back to the first symbol of the first segment. The `frame_start` marker identifies the first symbol of each period, so measurement equipment can align to the pattern. Mapping symbols to analog levels, scrambling and driving the line are done elsewhere.

Top module: `gtx_test_pattern_gen`

## Requirements
- R1: While `rst_n` is low, and on the first output cycle after reset, every lane is 0, `sym_valid` is low and `frame_start` is low. The pattern position returns to 0.
- R2: Each symbol is a two's-complement 3-bit code: +2 = 3'b010, +1 = 3'b001, 0 = 3'b000, -1 = 3'b111, -2 = 3'b110. No other code ever appears.
- R3: Positions 0, 128, 256 and 384 of the period carry +2, -2, +1 and -1 respectively. All other positions below 512 carry 0.
- R4: Positions 512 to 639 carry +2, and positions 640 to 767 carry -2.
- R5: Positions 768 to 1791 carry 0. After position 1791 the pattern continues at position 0, so the period is 1792 symbols.
- R6: `frame_start` is high exactly when the symbol on the outputs is position 0 of the period.
- R7: All four lanes carry the same symbol in every cycle.
- R8: After a clock edge where `run_en` is high and `restart` is low, the outputs show the symbol for the current position with `sym_valid` high, and the position advances by one.
- R9: After a clock edge where `run_en` is low, all lanes are 0 and `sym_valid` is low. The position is kept, so streaming resumes with the next symbol that was not yet sent.
- R10: `restart` takes precedence over `run_en`. After an edge with `restart` high, the outputs are invalid and zero, and the next valid symbol is position 0 with `frame_start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one symbol per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Streams symbols while high; holds output at zero while low |
| restart | input | 1 | Synchronous return to position 0 of the pattern |
| lane_sym | output | 12 | Four 3-bit symbols, lane n at bits [3n+2:3n] |
| sym_valid | output | 1 | High when lane_sym carries a pattern symbol |
| frame_start | output | 1 | High on the first symbol of each period |

## Verification
Every result is registered once. The symbol, valid flag and marker are therefore due one clock edge after the edge that samples `run_en`, `restart` and `rst_n`. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so every check sees the result of exactly one rising edge. A model of the position, written from the requirements, advances only on cycles that are expected to stream. This makes the resume point after a pause and the origin after a restart checkable cycle by cycle. A full period plus a wrap is compared, and table entries fix the values at the segment boundaries.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
// Package tpg_pkg
// Purpose : shared symbol type and code values for the test pattern generator.
// Assumes : symbols are 3-bit two's-complement values in the range -2..+2.
package tpg_pkg;
    localparam int SYM_W = 3;

    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t SYM_PLUS2  = 3'b010;
    localparam sym_t SYM_PLUS1  = 3'b001;
    localparam sym_t SYM_ZERO   = 3'b000;
    localparam sym_t SYM_MINUS1 = 3'b111;
    localparam sym_t SYM_MINUS2 = 3'b110;
endpackage

// File: rtl/tpg_position_counter.sv
`timescale 1ns/1ps
// Module tpg_position_counter
// Purpose : tracks the symbol index inside one pattern period.
// Assumes : PERIOD >= 2; restart wins over advance; reset is synchronous, active low.
module tpg_position_counter #(
    parameter int PERIOD = 1792,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          restart,
    output logic [CW-1:0] pos
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    // Step the index, wrap at the end of the period, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (restart) begin
            pos <= '0;
        end else if (advance) begin
            pos <= (pos == LAST) ? '0 : pos + CW'(1);
        end
    end
endmodule

// File: rtl/tpg_segment_decoder.sv
`timescale 1ns/1ps
// Module tpg_segment_decoder
// Purpose : maps a period index to its symbol and flags the period origin.
// Assumes : layout is four impulse blocks of IMP_LEN, two runs of RUN_LEN,
//           then QUIET_LEN zeros; purely combinational.
module tpg_segment_decoder
    import tpg_pkg::*;
#(
    parameter int IMP_LEN   = 128,
    parameter int RUN_LEN   = 128,
    parameter int QUIET_LEN = 1024,
    localparam int PERIOD   = 4 * IMP_LEN + 2 * RUN_LEN + QUIET_LEN,
    localparam int CW       = $clog2(PERIOD)
) (
    input  logic [CW-1:0] pos,
    output sym_t          sym,
    output logic          origin
);
    localparam int N_IMP = 4;
    localparam logic [CW-1:0] RUN_P_BASE = CW'(N_IMP * IMP_LEN);
    localparam logic [CW-1:0] RUN_N_BASE = CW'(N_IMP * IMP_LEN + RUN_LEN);
    localparam logic [CW-1:0] QUIET_BASE = CW'(N_IMP * IMP_LEN + 2 * RUN_LEN);

    // Impulse amplitude for each of the leading blocks, in play order.
    function automatic sym_t impulse_code(input int idx);
        case (idx)
            0:       return SYM_PLUS2;
            1:       return SYM_MINUS2;
            2:       return SYM_PLUS1;
            default: return SYM_MINUS1;
        endcase
    endfunction

    logic [N_IMP-1:0] imp_hit;

    // One comparator per impulse block start.
    for (genvar g = 0; g < N_IMP; g++) begin : g_imp
        localparam logic [CW-1:0] BASE = CW'(g * IMP_LEN);
        assign imp_hit[g] = (pos == BASE);
    end

    // Select the symbol of the segment that holds the index.
    always_comb begin
        sym = SYM_ZERO;
        for (int i = 0; i < N_IMP; i++) begin
            if (imp_hit[i]) sym = impulse_code(i);
        end
        if (pos >= RUN_P_BASE && pos < RUN_N_BASE) sym = SYM_PLUS2;
        if (pos >= RUN_N_BASE && pos < QUIET_BASE) sym = SYM_MINUS2;
    end

    assign origin = imp_hit[0];
endmodule

// File: rtl/tpg_lane_reg.sv
`timescale 1ns/1ps
// Module tpg_lane_reg
// Purpose : output register for one lane; loads the symbol or forces zero.
// Assumes : synchronous active-low reset; zero is the idle code.
module tpg_lane_reg
    import tpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  sym_t d,
    output sym_t q
);
    // Capture the symbol when streaming, otherwise drive the idle code.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SYM_ZERO;
        else        q <= load ? d : SYM_ZERO;
    end
endmodule

// File: rtl/gtx_test_pattern_gen.sv
`timescale 1ns/1ps
// Module gtx_test_pattern_gen
// Purpose : four-lane generator of the impulse / run / silence test pattern.
// Assumes : one symbol per clock; outputs registered once after the sampling
//           edge; restart has priority over run_en; reset is synchronous low.
module gtx_test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int IMP_LEN   = 128,
    parameter int RUN_LEN   = 128,
    parameter int QUIET_LEN = 1024,
    localparam int PERIOD   = 4 * IMP_LEN + 2 * RUN_LEN + QUIET_LEN,
    localparam int CW       = $clog2(PERIOD)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_en,
    input  logic                   restart,
    output logic [LANES*SYM_W-1:0] lane_sym,
    output logic                   sym_valid,
    output logic                   frame_start
);
    logic          advance;
    logic [CW-1:0] pos;
    sym_t          cur_sym;
    logic          cur_origin;

    assign advance = run_en & ~restart;

    tpg_position_counter #(.PERIOD(PERIOD)) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .restart (restart),
        .pos     (pos)
    );

    tpg_segment_decoder #(
        .IMP_LEN   (IMP_LEN),
        .RUN_LEN   (RUN_LEN),
        .QUIET_LEN (QUIET_LEN)
    ) decoder_i (
        .pos    (pos),
        .sym    (cur_sym),
        .origin (cur_origin)
    );

    // One output register per lane, all fed from the same decoded symbol.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        tpg_lane_reg lane_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (advance),
            .d     (cur_sym),
            .q     (lane_sym[l*SYM_W +: SYM_W])
        );
    end

    // Register the valid flag and the period marker alongside the symbols.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_valid   <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            sym_valid   <= advance;
            frame_start <= advance & cur_origin;
        end
    end
endmodule

// File: rtl/gtx_test_pattern_chk.sv
`timescale 1ns/1ps
// Module gtx_test_pattern_chk
// Purpose : temporal properties of the pattern generator ports.
// Assumes : bound to gtx_test_pattern_gen; observes ports only.
module gtx_test_pattern_chk #(
    parameter int LANES = 4,
    parameter int SYM_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   run_en,
    input logic                   restart,
    input logic [LANES*SYM_W-1:0] lane_sym,
    input logic                   sym_valid,
    input logic                   frame_start
);
    logic fresh;

    // Remember that the next valid symbol must be the period origin.
    always_ff @(posedge clk) begin
        if (!rst_n)         fresh <= 1'b1;
        else if (restart)   fresh <= 1'b1;
        else if (sym_valid) fresh <= 1'b0;
    end

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |-> (lane_sym == '0));

    assert_pause_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !sym_valid);

    assert_stream_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !restart) |=> sym_valid);

    assert_restart_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sym_valid);

    assert_restart_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh && sym_valid) |-> frame_start);

    assert_start_plus2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (sym_valid && lane_sym[SYM_W-1:0] == 3'b010));

    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_sym[l*SYM_W +: SYM_W] != 3'b011) &&
            (lane_sym[l*SYM_W +: SYM_W] != 3'b100) &&
            (lane_sym[l*SYM_W +: SYM_W] != 3'b101));

        assert_lanes_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
            lane_sym[l*SYM_W +: SYM_W] == lane_sym[SYM_W-1:0]);
    end
endmodule

bind gtx_test_pattern_gen gtx_test_pattern_chk #(
    .LANES (LANES),
    .SYM_W (tpg_pkg::SYM_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .restart     (restart),
    .lane_sym    (lane_sym),
    .sym_valid   (sym_valid),
    .frame_start (frame_start)
);

// File: tb/gtx_test_pattern_gen_tb_top.sv
`timescale 1ns/1ps
// Bench for gtx_test_pattern_gen: boundary vector table plus directed cases.
module gtx_test_pattern_gen_tb_top;
    localparam int PERIOD = 1792;
    localparam int N_VEC  = 16;

    typedef struct packed {
        logic [10:0] pos;
        logic [2:0]  code;
        logic        start;
    } vec_t;

    // Expected symbol at selected pattern positions (R3, R4, R5, R6, R2 codes).
    localparam vec_t VEC_TABLE [N_VEC] = '{
        '{11'd0,    3'b010, 1'b1},
        '{11'd1,    3'b000, 1'b0},
        '{11'd127,  3'b000, 1'b0},
        '{11'd128,  3'b110, 1'b0},
        '{11'd129,  3'b000, 1'b0},
        '{11'd256,  3'b001, 1'b0},
        '{11'd300,  3'b000, 1'b0},
        '{11'd384,  3'b111, 1'b0},
        '{11'd511,  3'b000, 1'b0},
        '{11'd512,  3'b010, 1'b0},
        '{11'd639,  3'b010, 1'b0},
        '{11'd640,  3'b110, 1'b0},
        '{11'd767,  3'b110, 1'b0},
        '{11'd768,  3'b000, 1'b0},
        '{11'd1500, 3'b000, 1'b0},
        '{11'd1791, 3'b000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        restart = 1'b0;
    logic [11:0] lane_sym;
    logic        sym_valid;
    logic        frame_start;

    int  n_vec = 0;
    int  n_bad = 0;
    int  exp_pos = 0;
    int  last_pos = -1;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    gtx_test_pattern_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .restart     (restart),
        .lane_sym    (lane_sym),
        .sym_valid   (sym_valid),
        .frame_start (frame_start)
    );

    // Symbol code at a period position, from the requirements.
    function automatic logic [2:0] ref_code(input int p);
        if (p == 0)               return 3'b010;
        if (p == 128)             return 3'b110;
        if (p == 256)             return 3'b001;
        if (p == 384)             return 3'b111;
        if (p >= 512 && p < 640)  return 3'b010;
        if (p >= 640 && p < 768)  return 3'b110;
        return 3'b000;
    endfunction

    task automatic check_out(input string req, input logic [11:0] e_sym,
                             input logic e_v, input logic e_s);
        n_vec++;
        if (lane_sym !== e_sym || sym_valid !== e_v || frame_start !== e_s) begin
            n_bad++;
            $display("FAIL %s: sym=%h valid=%b start=%b expected sym=%h valid=%b start=%b",
                     req, lane_sym, sym_valid, frame_start, e_sym, e_v, e_s);
        end
    endtask

    // Apply inputs at a falling edge, check the registered result one edge later.
    task automatic step(input bit r_n, input bit run, input bit rs, input string idle_tag);
        rst_n   = r_n;
        run_en  = run;
        restart = rs;
        @(negedge clk);
        if (!r_n || rs || !run) begin
            if (!r_n || rs) exp_pos = 0;
            last_pos = -1;
            check_out(idle_tag, 12'h000, 1'b0, 1'b0);
        end else begin
            last_pos = exp_pos;
            check_out((exp_pos == 0) ? "R6 R7" : "R7 R8", {4{ref_code(exp_pos)}},
                      1'b1, exp_pos == 0);
            exp_pos = (exp_pos + 1) % PERIOD;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        int idx;
        // R1: reset holds everything idle, even with run_en high.
        step(1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, "R1");
        // R9: out of reset but not enabled.
        step(1'b1, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b0, 1'b0, "R9");
        // R10: restart with run_en high stays idle.
        step(1'b1, 1'b1, 1'b1, "R10");

        // Walk one full period plus a wrap against the boundary table.
        idx = 0;
        for (int c = 0; c < PERIOD + 8; c++) begin
            step(1'b1, 1'b1, 1'b0, "R8");
            if (idx < N_VEC && last_pos == int'(VEC_TABLE[idx].pos)) begin
                check_out((last_pos < 512) ? "R3" : (last_pos < 768) ? "R4" : "R5",
                          {4{VEC_TABLE[idx].code}}, 1'b1, VEC_TABLE[idx].start);
                idx++;
            end
        end
        if (idx != N_VEC) begin
            n_vec++;
            n_bad++;
            $display("FAIL R5: table entries reached=%0d expected=%0d", idx, N_VEC);
        end

        // R9: pause just before the -1 impulse; resume must deliver it.
        step(1'b1, 1'b1, 1'b1, "R10");
        for (int c = 0; c < 384; c++) step(1'b1, 1'b1, 1'b0, "R8");
        for (int c = 0; c < 3; c++) step(1'b1, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b1, 1'b0, "R9");
        check_out("R9", {4{3'b111}}, 1'b1, 1'b0);

        // R10: restart in the middle of the +2 run, next symbol is the origin.
        for (int c = 0; c < 200; c++) step(1'b1, 1'b1, 1'b0, "R8");
        step(1'b1, 1'b1, 1'b1, "R10");
        step(1'b1, 1'b1, 1'b0, "R10");
        check_out("R10", {4{3'b010}}, 1'b1, 1'b1);

        // R1: reset in mid-stream returns to the origin.
        for (int c = 0; c < 140; c++) step(1'b1, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b0, "R1");
        check_out("R1", {4{3'b010}}, 1'b1, 1'b1);
        for (int c = 0; c < 130; c++) step(1'b1, 1'b1, 1'b0, "R8");

        done = 1'b1;
        finish_run();
    end
endmodule